// File: doc/BRIEF.md
# Three-Channel Capture Timer

This block measures the timing of external events. A 24-bit up-counter advances once per count tick. Each of three capture channels receives a single-cycle event pulse, already filtered and edge-qualified upstream. When a pulse arrives, the channel copies the counter into its own hold register. Software can later read the hold registers to work out the time between events.

Around that core sits a compare register. It can flag a match and wrap the counter back to zero. Each capture event, and the counter overflow, can reload the counter from the compare value, and each capture event can also clear the counter. Five sticky flags record captures, matches and overflows, and a masked OR of those flags drives one interrupt line. The count tick comes either from a prescaler with eight divide ratios or from the event pulse of one chosen channel.

Software reaches the block through a simple word-wide port. A write is a one-cycle strobe with an address and data. A read is a combinational lookup by address. Addresses: 0 counter, 1–3 hold registers of channels 0–2, 4 compare value, 5 control, 6 status.

Top module: `cap_timer`

## Requirements
- R1: The counter resets to 0. It advances by exactly one per tick, and only while control bit 0 (run) and control bit 1 (count enable) are both 1. With no tick, clear or reload it keeps its value.
- R2: While run is set, an event pulse on channel n copies the counter value of that cycle into hold register n (read at address 1+n). The copied value is the one from before any clear or reload in the same cycle.
- R3: Compare is enabled by control bit 2. When an increment makes the counter equal the compare value (address 4), status bit 3 is set. If control bit 3 is also set, the counter becomes 0 instead.
- R4: An increment from 0xFFFFFF wraps the counter to 0 and sets status bit 4.
- R5: Control bits 11:9 let the events of channels 0–2 load the compare value into the counter. Control bit 12 makes an overflow load the compare value instead of 0.
- R6: Control bits 15:13 let the events of channels 0–2 clear the counter to 0. A clear wins over a reload, and over any increment, in the same cycle.
- R7: Status bits 2:0 (capture, per channel), 3 (match) and 4 (overflow) are sticky. Writing 1 to a bit at address 6 clears it. A hardware set in the same cycle as the clear leaves the bit at 1.
- R8: irq is 1 exactly when some status bit in 4:0 is 1 and its enable is set. The enables are control bits 20:16, in the same order as the status bits.
- R9: Control bits 6:4 choose the prescale ratio: codes 0–7 divide by 1, 4, 16, 32, 64, 96, 112 and 128. The first tick after counting starts, or after the code changes, comes after a full period.
- R10: Control bits 8:7 choose the tick source: 0 is the prescaler, and 1, 2 and 3 are the event pulses of channels 0, 1 and 2.
- R11: Status bits 7:5 show the conditioned levels of channels 0–2 as they are presented.
- R12: While run is 0, event pulses capture nothing, set no flag, and neither clear nor reload the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| evt_pulse | input | 3 | Single-cycle qualified edge events, one per channel |
| evt_level | input | 3 | Conditioned input levels, one per channel |
| irq | output | 1 | Combined masked interrupt |

## Verification
The counter is driven by the prescaler at every divide code, including code changes in mid-period. This separates an exact divide from an off-by-one and from a missing restart. Events arrive alone, together, with clear and reload enabled at once, and while run is off, which tells the priority order apart and shows whether the hold value is taken before or after the update. Compare and overflow are driven to their boundary values (a match with clear, a wrap with and without reload). Status is written to clear in the same cycle as a hardware set, and a long random phase mixes every control field against the reference.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int NCH     = 3;
  localparam int DIV_MAX = 128;
  localparam int NFLAG   = 5;

  // register addresses
  localparam logic [2:0] A_CNT  = 3'd0;
  localparam logic [2:0] A_HOLD = 3'd1;  // channels at A_HOLD + n
  localparam logic [2:0] A_CMP  = 3'd4;
  localparam logic [2:0] A_CTL  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;

  // control field positions
  localparam int C_RUN   = 0;
  localparam int C_CNTEN = 1;
  localparam int C_CMPEN = 2;
  localparam int C_MCLR  = 3;
  localparam int C_DIV   = 4;   // 3 bits
  localparam int C_SRC   = 7;   // 2 bits
  localparam int C_ERLD  = 9;   // NCH bits
  localparam int C_ORLD  = 12;
  localparam int C_ECLR  = 13;  // NCH bits
  localparam int C_IEN   = 16;  // NFLAG bits
  localparam int CTL_W   = 21;

  // status flag positions
  localparam int F_MATCH = 3;
  localparam int F_OVF   = 4;

  function automatic int unsigned div_of(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 16;
      3'd3:    return 32;
      3'd4:    return 64;
      3'd5:    return 96;
      3'd6:    return 112;
      default: return 128;
    endcase
  endfunction
endpackage

// File: rtl/cap_tick_gen.sv
module cap_tick_gen
  import cap_timer_pkg::*;
#(
  parameter int PW = $clog2(DIV_MAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           counting,
  input  logic           restart,
  input  logic [2:0]     div_code,
  input  logic [1:0]     src,
  input  logic [NCH-1:0] evt,
  output logic           tick
);
  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;
  logic          pre_hit;
  logic          evt_tick;

  assign lim     = PW'(div_of(div_code) - 1);
  assign pre_hit = (pre_q == lim);

  always_comb begin
    evt_tick = 1'b0;
    for (int k = 0; k < NCH; k++)
      if (src == 2'(k + 1)) evt_tick = evt[k];
  end

  assign tick = counting && ((src == 2'd0) ? pre_hit : evt_tick);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || !counting) pre_q <= '0;
    else if (pre_hit)                  pre_q <= '0;
    else                               pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cap_count_core.sv
module cap_count_core #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr_req,
  input  logic          rld_req,
  input  logic          cmp_en,
  input  logic          match_clr,
  input  logic          ovf_rld,
  input  logic [CW-1:0] cmp_val,
  output logic [CW-1:0] cnt,
  output logic          match_evt,
  output logic          ovf_evt
);
  function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic at_top(input logic [CW-1:0] v);
    return &v;
  endfunction

  logic          step;
  logic [CW-1:0] nxt_inc;
  logic [CW-1:0] cnt_d;

  assign step      = tick && !clr_req && !rld_req;
  assign nxt_inc   = bump(cnt);
  assign match_evt = step && cmp_en && (nxt_inc == cmp_val);
  assign ovf_evt   = step && at_top(cnt);

  always_comb begin
    if (clr_req)                     cnt_d = '0;
    else if (rld_req)                cnt_d = cmp_val;
    else if (match_evt && match_clr) cnt_d = '0;
    else if (ovf_evt && ovf_rld)     cnt_d = cmp_val;
    else if (step)                   cnt_d = nxt_inc;
    else                             cnt_d = cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/cap_hold_bank.sv
module cap_hold_bank #(
  parameter int CW  = 24,
  parameter int NCH = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         cap_evt,
  input  logic [CW-1:0]          cnt,
  output logic [NCH-1:0][CW-1:0] hold
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)          hold[i] <= '0;
      else if (cap_evt[i]) hold[i] <= cnt;
    end
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [2:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [2:0]    evt_pulse,
  input  logic [2:0]    evt_level,
  output logic          irq
);
  localparam int PW = $clog2(DIV_MAX);

  logic [CTL_W-1:0]         ctl_q;
  logic [CW-1:0]            cmp_q;
  logic [NFLAG-1:0]         flag_q;
  logic [CW-1:0]            cnt_q;
  logic [NCH-1:0][CW-1:0]   hold_q;

  logic                     run, counting, tick, restart;
  logic [NCH-1:0]           cap_evt;
  logic                     clr_req, rld_req, match_evt, ovf_evt;
  logic [NFLAG-1:0]         flag_set, flag_clr;
  logic                     wr_ctl, wr_cmp, wr_stat;

  assign wr_ctl  = wr_en && (wr_addr == A_CTL);
  assign wr_cmp  = wr_en && (wr_addr == A_CMP);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  assign run      = ctl_q[C_RUN];
  assign counting = run && ctl_q[C_CNTEN];
  assign cap_evt  = evt_pulse & {NCH{run}};
  assign clr_req  = |(cap_evt & ctl_q[C_ECLR +: NCH]);
  assign rld_req  = |(cap_evt & ctl_q[C_ERLD +: NCH]);
  assign restart  = wr_ctl && (wr_data[C_DIV +: 3] != ctl_q[C_DIV +: 3]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= wr_data[CTL_W-1:0];
      if (wr_cmp) cmp_q <= wr_data[CW-1:0];
    end
  end

  cap_tick_gen #(.PW(PW)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .counting (counting),
    .restart  (restart),
    .div_code (ctl_q[C_DIV +: 3]),
    .src      (ctl_q[C_SRC +: 2]),
    .evt      (evt_pulse),
    .tick     (tick)
  );

  cap_count_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .clr_req   (clr_req),
    .rld_req   (rld_req),
    .cmp_en    (ctl_q[C_CMPEN]),
    .match_clr (ctl_q[C_MCLR]),
    .ovf_rld   (ctl_q[C_ORLD]),
    .cmp_val   (cmp_q),
    .cnt       (cnt_q),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt)
  );

  cap_hold_bank #(.CW(CW), .NCH(NCH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_evt (cap_evt),
    .cnt     (cnt_q),
    .hold    (hold_q)
  );

  // sticky flags: a hardware set wins over a same-cycle software clear
  assign flag_set = {ovf_evt, match_evt, cap_evt};
  assign flag_clr = wr_stat ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  assign irq = |(flag_q & ctl_q[C_IEN +: NFLAG]);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CNT:        rd_data[CW-1:0]    = cnt_q;
      3'd1, 3'd2, 3'd3:
                    rd_data[CW-1:0]    = hold_q[2'(rd_addr - A_HOLD)];
      A_CMP:        rd_data[CW-1:0]    = cmp_q;
      A_CTL:        rd_data[CTL_W-1:0] = ctl_q;
      A_STAT: begin
                    rd_data[NFLAG-1:0] = flag_q;
                    rd_data[NFLAG +: NCH] = evt_level;
      end
      default:      rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
  import cap_timer_pkg::*;
#(
  parameter int CW = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [CW-1:0]          cnt,
  input logic [NCH-1:0][CW-1:0] hold,
  input logic [NCH-1:0]         cap_evt,
  input logic                   tick,
  input logic                   clr_req,
  input logic                   rld_req,
  input logic                   match_evt,
  input logic                   ovf_evt,
  input logic [NFLAG-1:0]       flags,
  input logic [NFLAG-1:0]       flag_clr,
  input logic                   irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_hold
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> hold[i] == $past(cnt));
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_req && !rld_req) |=> $stable(cnt));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_req && !rld_req && !match_evt && !ovf_evt) |=> cnt == $past(cnt) + 1'b1);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> cnt == '0);

  p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flags[F_MATCH]);

  p_ovf_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags[F_OVF]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[F_OVF]) |-> $past(flag_clr[F_OVF]));

  p_quiet_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);
endmodule

bind cap_timer cap_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt       (cnt_q),
  .hold      (hold_q),
  .cap_evt   (cap_evt),
  .tick      (tick),
  .clr_req   (clr_req),
  .rld_req   (rld_req),
  .match_evt (match_evt),
  .ovf_evt   (ovf_evt),
  .flags     (flag_q),
  .flag_clr  (flag_clr),
  .irq       (irq)
);

// File: tb/cap_timer_tb.sv
`timescale 1ns/100ps
module cap_timer_tb;
  localparam int MAXV = 24'hFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  evt_pulse = '0;
  logic [2:0]  evt_level = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse), .evt_level(evt_level),
    .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_cnt, m_cmp, m_ctl, m_flags, m_pre;
  int m_hold [3];
  int divtab [8] = '{1, 4, 16, 32, 64, 96, 112, 128};

  function automatic int fld(int v, int lo, int w);
    return (v >> lo) & ((1 << w) - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_ctl = 0; m_flags = 0; m_pre = 0;
      foreach (m_hold[i]) m_hold[i] = 0;
    end else begin
      int old, nxt, setf, clrf, src, dv;
      bit on, going, tk, clr, rld, ovf, mat;
      old = m_cnt;
      on = fld(m_ctl, 0, 1) != 0;
      going = on && fld(m_ctl, 1, 1) != 0;
      src = fld(m_ctl, 7, 2);
      dv = divtab[fld(m_ctl, 4, 3)];
      if (src == 0) tk = going && (m_pre == dv - 1);
      else          tk = going && evt_pulse[src-1];
      clr = 0; rld = 0; setf = 0;
      for (int i = 0; i < 3; i++) begin
        if (on && evt_pulse[i]) begin
          m_hold[i] = old;
          setf |= (1 << i);
          if (fld(m_ctl, 13 + i, 1) != 0) clr = 1;
          if (fld(m_ctl, 9 + i, 1) != 0)  rld = 1;
        end
      end
      ovf = 0; mat = 0;
      if (clr)      m_cnt = 0;
      else if (rld) m_cnt = m_cmp;
      else if (tk) begin
        if (old == MAXV) begin ovf = 1; nxt = 0; end
        else nxt = old + 1;
        if (fld(m_ctl, 2, 1) != 0 && nxt == m_cmp) mat = 1;
        if (mat && fld(m_ctl, 3, 1) != 0)      m_cnt = 0;
        else if (ovf && fld(m_ctl, 12, 1) != 0) m_cnt = m_cmp;
        else                                    m_cnt = nxt;
      end
      if (mat) setf |= 8;
      if (ovf) setf |= 16;
      clrf = (wr_en && wr_addr == 3'd6) ? int'(wr_data[4:0]) : 0;
      m_flags = (m_flags & ~clrf) | setf;
      // prescaler phase
      if (wr_en && wr_addr == 3'd5 && int'(wr_data[6:4]) != fld(m_ctl, 4, 3)) m_pre = 0;
      else if (!going)       m_pre = 0;
      else if (m_pre == dv - 1) m_pre = 0;
      else                   m_pre = m_pre + 1;
      if (wr_en && wr_addr == 3'd5) m_ctl = int'(wr_data[20:0]);
      if (wr_en && wr_addr == 3'd4) m_cmp = int'(wr_data[23:0]);
    end
  end

  function automatic int model_rd(int a);
    case (a)
      0: return m_cnt;
      1, 2, 3: return m_hold[a-1];
      4: return m_cmp;
      5: return m_ctl;
      6: return m_flags | (int'(evt_level) << 5);
      default: return 0;
    endcase
  endfunction

  function automatic bit model_irq();
    return (m_flags & fld(m_ctl, 16, 5)) != 0;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic peek(input int a, output int v);
    rd_addr = 3'(a);
    #0.2;
    v = int'(rd_data);
  endtask

  // one clock: inputs set by caller are applied at the edge, then all
  // readouts are compared with the model, then strobes drop
  task automatic step();
    string tags [7] = '{"R1 counter", "R2 hold0", "R2 hold1", "R2 hold2",
                        "R5 compare value", "R10 control readback", "R7/R11 status"};
    @(posedge clk);
    #0.5;
    for (int a = 0; a < 7; a++) begin
      int v;
      peek(a, v);
      chk(tags[a], v, model_rd(a));
    end
    chk("R8 irq", int'(irq), int'(model_irq()));
    wr_en = 1'b0;
    evt_pulse = '0;
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 32'(d);
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(input logic [2:0] p);
    evt_pulse = p;
    step();
  endtask

  // control word builder
  function automatic int ctl(bit run, bit cen, bit cmpen, bit mclr, int dv, int src,
                             int erld, bit orld, int eclr, int ien);
    return int'(run) | (int'(cen) << 1) | (int'(cmpen) << 2) | (int'(mclr) << 3) |
           (dv << 4) | (src << 7) | (erld << 9) | (int'(orld) << 12) |
           (eclr << 13) | (ien << 16);
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 8);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int v, k;
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    #0.5;
    peek(0, v); chk("R1 reset counter", v, 0);
    peek(6, v); chk("R7 reset status", v, 0);
    chk("R8 reset irq", int'(irq), 0);

    // R11: levels reflected
    evt_level = 3'b101;
    peek(6, v); chk("R11 level bits", (v >> 5) & 7, 5);
    evt_level = 3'b010;
    peek(6, v); chk("R11 level bits", (v >> 5) & 7, 2);

    // R12: events ignored while run is 0
    wr(3'd5, ctl(0, 1, 0, 0, 0, 0, 0, 0, 7, 7));
    pulse(3'b111);
    idle(2);
    peek(1, v); chk("R12 no capture when stopped", v, 0);
    peek(6, v); chk("R12 no flag when stopped", v & 7, 0);

    // free run, prescaler /1, captures on each channel
    wr(3'd5, ctl(1, 1, 0, 0, 0, 0, 0, 0, 0, 5'b00111));
    idle(5);
    pulse(3'b001); idle(3); pulse(3'b010); idle(2); pulse(3'b100); pulse(3'b111);
    wr(3'd6, 7);

    // R9: every divide code, first tick after a full period
    for (int c = 0; c < 8; c++) begin
      wr(3'd5, ctl(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
      pulse(3'b001);                               // clear counter
      wr(3'd5, ctl(1, 1, 0, 0, c, 0, 0, 0, 1, 0));
      k = 0;
      peek(0, v);
      while (v == 0 && k < 300) begin step(); k++; peek(0, v); end
      chk("R9 first tick period", k, divtab[c]);
      idle(2 * divtab[c] + 3);
    end
    // R9: code change mid-period restarts the phase
    wr(3'd5, ctl(1, 1, 0, 0, 2, 0, 0, 0, 0, 0));
    idle(10);
    wr(3'd5, ctl(1, 1, 0, 0, 1, 0, 0, 0, 0, 0));
    idle(20);

    // R3: compare match with clear
    wr(3'd4, 50);
    wr(3'd5, ctl(1, 0, 0, 0, 0, 0, 0, 0, 1, 0));
    pulse(3'b001);
    wr(3'd6, 31);
    wr(3'd5, ctl(1, 1, 1, 1, 0, 0, 0, 0, 0, 5'b01000));
    idle(120);
    peek(6, v); chk("R3 match flag", (v >> 3) & 1, 1);
    peek(0, v); chk("R3 counter wrapped by match", int'(v < 50), 1);
    chk("R8 irq on match", int'(irq), 1);
    // compare without clear keeps counting past the value
    wr(3'd5, ctl(1, 1, 1, 0, 0, 0, 0, 0, 0, 0));
    idle(80);

    // R5/R4: reload near the top, overflow, then overflow reload
    wr(3'd4, 24'hFFFFF0);
    wr(3'd5, ctl(1, 1, 0, 0, 0, 0, 1, 0, 0, 5'b10000));
    wr(3'd6, 31);
    pulse(3'b001);
    peek(0, v); chk("R5 event reload", v, 24'hFFFFF0);
    idle(20);
    peek(6, v); chk("R4 overflow flag", (v >> 4) & 1, 1);
    chk("R8 irq on overflow", int'(irq), 1);
    wr(3'd5, ctl(1, 1, 0, 0, 0, 0, 1, 1, 0, 0));
    pulse(3'b001);
    idle(40);

    // R6: clear and reload together, clear wins; hold sees pre-update value
    wr(3'd4, 1234);
    wr(3'd5, ctl(1, 1, 0, 0, 0, 0, 3'b110, 0, 3'b010, 0));
    idle(7);
    pulse(3'b110);
    peek(0, v); chk("R6 clear beats reload", v, 0);
    idle(5);
    pulse(3'b100);
    peek(0, v); chk("R5 reload alone", v, 1234);

    // R10: tick from a channel event
    for (int s = 1; s < 4; s++) begin
      wr(3'd5, ctl(1, 0, 0, 0, 0, 0, 0, 0, 3'b001, 0));
      pulse(3'b001);
      wr(3'd5, ctl(1, 1, 0, 0, 0, s, 0, 0, 0, 0));
      for (int j = 0; j < 5; j++) begin pulse(3'(1 << (s - 1))); idle(3); end
      idle(10);
      peek(0, v); chk("R10 event-driven ticks", v, (s == 1) ? 5 : 5);
    end

    // R7: software clear in the same cycle as a hardware set
    wr(3'd5, ctl(1, 1, 0, 0, 0, 0, 0, 0, 0, 5'b00111));
    pulse(3'b011);
    evt_pulse = 3'b001; wr(3'd6, 3);
    peek(6, v); chk("R7 set wins over clear", v & 3, 1);
    wr(3'd6, 1);
    peek(6, v); chk("R7 write-one clears", v & 3, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt_level = 3'($urandom);
      if (r < 3) begin
        int c;
        c = int'($urandom) & 32'h1F_FFFF;
        if ($urandom_range(0, 7) != 0) c |= 3;
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'(c);
      end else if (r < 5) begin
        wr_en = 1'b1; wr_addr = 3'd4;
        wr_data = ($urandom_range(0, 1) != 0) ? 32'(24'hFFFF00 | $urandom_range(0, 255))
                                              : 32'($urandom_range(0, 400));
      end else if (r < 10) begin
        wr_en = 1'b1; wr_addr = 3'd6; wr_data = 32'($urandom);
      end
      if ($urandom_range(0, 9) == 0) evt_pulse = 3'($urandom);
      step();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule